// File: doc/BRIEF.md
# Reloadable 16-bit Interval Timer

This block is a down-counting interval timer for a peripheral chip with a byte-wide register bus. Software loads a 16-bit reload value in two byte writes and controls the timer through one control byte. That byte holds a start bit, a one-shot bit, a force-load strobe, a port-output enable, an output-form select and a count-source field. While the timer is started and the count source selects the system clock, the counter steps down once per clock. When it passes zero it reloads itself from the latch, sends a one-cycle request to the interrupt controller and inverts a toggle flip-flop.

The timer output can take over one port pin, either as the toggle level or as a one-clock pulse at each underflow. Software can read the live counter at any time as two bytes. The parameter `SRC_W` sets the width of the count-source field: 1 for the first timer of a pair and 2 for the second. A source value of zero means the system clock. Any other source value parks the counter.

The run state is held in a three-state machine. `ST_IDLE` means stopped. `ST_RUN` means started and counting clocks. `ST_PARK` means started with a source that is not the clock. The transitions are: start-write (IDLE to RUN or PARK, chosen by the source field), stop-write (RUN or PARK to IDLE), source-write (RUN to PARK, or PARK to RUN), and one-shot-expire (RUN to IDLE on underflow with the one-shot bit set).

Top module: `ivt_timer`

## Requirements
- R1: After reset, the counter, latch and control byte all read 0, `irq_req` is 0, and `port_out` equals `port_in`.
- R2: Register address 0 writes the latch low byte and address 1 writes the latch high byte. A high-byte write while the start bit (control bit 0) is 0 also loads the counter with the new 16-bit latch value. While the start bit is 1, the counter is not disturbed.
- R3: Reads at address 0 and address 1 return the live counter's low and high bytes. The counter falls by one per clock only while the start bit is 1 and the source field (bits starting at bit 5, `SRC_W` wide) is 0. Otherwise it holds.
- R4: On a counting clock with the counter at 0, the counter reloads from the latch and `irq_req` is high for the following cycle.
- R5: A control write (address 2) with bit 4 set copies the latch into the counter. Bit 4 always reads back as 0.
- R6: A control write that takes the start bit from 0 to 1 reloads the counter from the latch and sets the toggle flip-flop to 1.
- R7: With control bit 3 set, an underflow clears the start bit, so the counter then holds the reloaded value.
- R8: With control bit 1 at 0, `port_out` follows `port_in`. With bit 1 at 1, `port_out` shows the toggle level when bit 2 is 1, and a one-cycle pulse in the cycle after an underflow when bit 2 is 0.
- R9: Each underflow inverts the toggle flip-flop.
- R10: A clock cycle carrying a control write neither decrements nor underflows the counter. A load requested by that write takes effect instead.
- R11: A read of the control byte (address 2) returns the last written value with bit 4 cleared, and with bit 0 cleared after a one-shot expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register select: 0 count/latch low, 1 count/latch high, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| port_in | input | 1 | Port data for the pin the timer can take over |
| port_out | output | 1 | Pin value after the timer override |
| irq_req | output | 1 | One-cycle underflow request to the interrupt controller |

## Verification
The delicate collision is a control-register write landing on the same clock as a counter underflow. The write must win: there is no reload from underflow, no request and no toggle, and the underflow follows one clock later. The bench provokes this by polling the counter down to zero and issuing a control write at that exact clock, then checks `irq_req` in that cycle and the next. A second collision is a high-byte write while the timer is started, which must leave the counter counting. Random traffic with short reload values then produces many chance overlaps of writes and underflows, each judged against a cycle model built from the requirements.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PARK = 2'd2
    } run_state_e;

    localparam logic [1:0] A_CNT_LO = 2'd0;
    localparam logic [1:0] A_CNT_HI = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;

    localparam int B_START   = 0;
    localparam int B_PORT_EN = 1;
    localparam int B_TOGGLE  = 2;
    localparam int B_ONESHOT = 3;
    localparam int B_FORCE   = 4;
    localparam int B_SRC     = 5;

endpackage

// File: rtl/ivt_latch.sv
module ivt_latch #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  latch_q,
    output logic [CNT_W-1:0]  hi_val
);

    // value the latch takes on a high-byte write
    assign hi_val = {wdata, latch_q[BYTE_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_lo) begin
            latch_q[BYTE_W-1:0] <= wdata;
        end else if (wr_hi) begin
            latch_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

endmodule

// File: rtl/ivt_seq.sv
module ivt_seq
    import ivt_pkg::*;
#(
    parameter int SRC_W  = 1,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              underflow,
    output run_state_e        state,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              run_en,
    output logic              start_edge,
    output logic              force_ld
);

    localparam logic [BYTE_W-1:0] KEEP_MASK =
        ~((BYTE_W'(1) << B_START) | (BYTE_W'(1) << B_FORCE));

    run_state_e        state_q, state_d;
    logic [BYTE_W-1:0] rest_q;
    logic              src_clk_w;

    assign src_clk_w = (wdata[B_SRC +: SRC_W] == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wdata[B_START]) begin
                    state_d = src_clk_w ? ST_RUN : ST_PARK;   // start-write
                end
            end
            ST_RUN: begin
                if (ctrl_wr) begin
                    if (!wdata[B_START])  state_d = ST_IDLE;  // stop-write
                    else if (!src_clk_w)  state_d = ST_PARK;  // source-write
                end else if (underflow && rest_q[B_ONESHOT]) begin
                    state_d = ST_IDLE;                        // one-shot-expire
                end
            end
            ST_PARK: begin
                if (ctrl_wr) begin
                    if (!wdata[B_START])  state_d = ST_IDLE;  // stop-write
                    else if (src_clk_w)   state_d = ST_RUN;   // source-write
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // stored control bits other than start and force-load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rest_q <= '0;
        else if (ctrl_wr) rest_q <= wdata & KEEP_MASK;
    end

    // outputs
    always_comb begin
        state      = state_q;
        run_en     = (state_q == ST_RUN);
        start_edge = ctrl_wr && wdata[B_START] && (state_q == ST_IDLE);
        force_ld   = ctrl_wr && wdata[B_FORCE];
        ctrl_q     = rest_q;
        ctrl_q[B_START] = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             ctrl_wr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick,
    output logic             underflow
);

    // a control write cycle suspends counting
    assign tick      = run_en && !ctrl_wr;
    assign underflow = tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (underflow) begin
            cnt_q <= latch_q;
        end else if (tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ivt_outgen.sv
module ivt_outgen (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow,
    input  logic start_edge,
    input  logic port_en,
    input  logic toggle_mode,
    input  logic port_in,
    output logic port_out,
    output logic irq_req
);

    logic tog_q;
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= underflow;
            if (start_edge)     tog_q <= 1'b1;
            else if (underflow) tog_q <= ~tog_q;
        end
    end

    assign irq_req  = pulse_q;
    assign port_out = port_en ? (toggle_mode ? tog_q : pulse_q) : port_in;

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int SRC_W  = 1,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              port_in,
    output logic              port_out,
    output logic              irq_req
);

    localparam int CNT_W = 2 * BYTE_W;

    logic              wr_lo, wr_hi, ctrl_wr;
    logic [CNT_W-1:0]  latch_q, hi_val, cnt_q, load_val;
    logic [BYTE_W-1:0] ctrl_q;
    logic              run_en, start_edge, force_ld, tick, underflow;
    logic              hi_load, load;
    run_state_e        st;

    assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    ivt_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .hi_val  (hi_val)
    );

    ivt_seq #(.SRC_W(SRC_W), .BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wdata      (bus_wdata),
        .underflow  (underflow),
        .state      (st),
        .ctrl_q     (ctrl_q),
        .run_en     (run_en),
        .start_edge (start_edge),
        .force_ld   (force_ld)
    );

    // high-byte write loads only while stopped; control loads use the old latch
    assign hi_load  = wr_hi && (st == ST_IDLE);
    assign load     = hi_load || start_edge || force_ld;
    assign load_val = hi_load ? hi_val : latch_q;

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ctrl_wr   (ctrl_wr),
        .load      (load),
        .load_val  (load_val),
        .latch_q   (latch_q),
        .cnt_q     (cnt_q),
        .tick      (tick),
        .underflow (underflow)
    );

    ivt_outgen u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .underflow   (underflow),
        .start_edge  (start_edge),
        .port_en     (ctrl_q[B_PORT_EN]),
        .toggle_mode (ctrl_q[B_TOGGLE]),
        .port_in     (port_in),
        .port_out    (port_out),
        .irq_req     (irq_req)
    );

    always_comb begin
        unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CTRL:   bus_rdata = ctrl_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              port_in,
    input logic              port_out,
    input logic              irq_req,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  lat,
    input logic              tick,
    input logic [BYTE_W-1:0] ctrl
);

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R4
    reload_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0) |=> (irq_req && cnt == $past(lat)));

    // R10
    ctrl_wr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL) |=> !irq_req);

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && ctrl[B_ONESHOT]) |=> !ctrl[B_START]);

    // R5
    force_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> !bus_rdata[B_FORCE]);

    // R8
    port_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[B_PORT_EN] |-> (port_out == port_in));

endmodule

bind ivt_timer ivt_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .port_in   (port_in),
    .port_out  (port_out),
    .irq_req   (irq_req),
    .cnt       (cnt_q),
    .lat       (latch_q),
    .tick      (tick),
    .ctrl      (ctrl_q)
);

// File: tb/test_ivt_timer.sv
module test_ivt_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       port_in = 1'b0;
    logic       port_out;
    logic       irq_req;

    always #10 clk = ~clk;

    ivt_timer #(.SRC_W(2), .BYTE_W(8)) i_ivt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_in   (port_in),
        .port_out  (port_out),
        .irq_req   (irq_req)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // cycle model built from the requirements
    logic [15:0] m_cnt = '0;
    logic [15:0] m_lat = '0;
    logic [7:0]  m_ctl = '0;
    logic        m_tog = 1'b0;
    logic        m_pls = 1'b0;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(logic [1:0] a);
        case (a)
            2'd0:    return m_cnt[7:0];
            2'd1:    return m_cnt[15:8];
            2'd2:    return m_ctl;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic m_port(logic pin);
        if (!m_ctl[1]) return pin;
        return m_ctl[2] ? m_tog : m_pls;
    endfunction

    task automatic m_update(bit wr, logic [1:0] a, logic [7:0] d);
        bit          cw  = wr && (a == 2'd2);
        bit          run = m_ctl[0] && (m_ctl[6:5] == 2'b00);
        bit          tk  = run && !cw;
        bit          uf  = tk && (m_cnt == 16'd0);
        logic [15:0] nc  = m_cnt;
        logic [15:0] nl  = m_lat;
        logic [7:0]  nct = m_ctl;
        logic        nt  = m_tog;
        if (uf) begin
            nc = m_lat;
            nt = ~m_tog;
            if (m_ctl[3]) nct[0] = 1'b0;
        end else if (tk) begin
            nc = m_cnt - 16'd1;
        end
        if (wr && a == 2'd0) nl[7:0] = d;
        if (wr && a == 2'd1) begin
            nl[15:8] = d;
            if (!m_ctl[0]) nc = nl;
        end
        if (cw) begin
            if (d[0] && !m_ctl[0]) begin
                nc = m_lat;
                nt = 1'b1;
            end
            if (d[4]) nc = m_lat;
            nct = d & 8'hEF;
        end
        m_cnt = nc;
        m_lat = nl;
        m_ctl = nct;
        m_tog = nt;
        m_pls = uf;
    endtask

    // one bus cycle; checks readback, request and pin after the edge
    task automatic step(bit wr, logic [1:0] a, logic [7:0] d, bit pin);
        @(negedge clk);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        port_in   = pin;
        @(posedge clk);
        m_update(wr, a, d);
        #1;
        bus_wr = 1'b0;
        chk("R3 readback", 16'(bus_rdata), 16'(m_read(a)));
        chk("R4 irq_req", 16'(irq_req), 16'(m_pls));
        chk("R8 port_out", 16'(port_out), 16'(m_port(pin)));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4021));
        // R1 reset state
        port_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        bus_addr = 2'd0; #1; chk("R1 count lo", 16'(bus_rdata), 16'h0);
        bus_addr = 2'd1; #1; chk("R1 count hi", 16'(bus_rdata), 16'h0);
        bus_addr = 2'd2; #1; chk("R1 ctrl", 16'(bus_rdata), 16'h0);
        chk("R1 irq", 16'(irq_req), 16'h0);
        chk("R1 port", 16'(port_out), 16'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 load while stopped
        step(1, 2'd0, 8'h34, 0);
        step(1, 2'd1, 8'h12, 0);
        step(0, 2'd0, 8'h00, 0);
        chk("R2 stopped load lo", 16'(bus_rdata), 16'h34);
        step(0, 2'd1, 8'h00, 0);
        chk("R2 stopped load hi", 16'(bus_rdata), 16'h12);

        // R6 start edge with toggle output on the pin
        step(1, 2'd2, 8'h07, 0);
        chk("R6 toggle set", 16'(port_out), 16'h1);
        step(0, 2'd0, 8'h00, 0);
        chk("R6 reload then step", 16'(bus_rdata), 16'h33);

        // R2 high byte while running leaves counter alone
        step(1, 2'd1, 8'h00, 0);
        step(0, 2'd1, 8'h00, 0);
        chk("R2 running no load", 16'(bus_rdata), 16'h12);

        // R5 force load, R11 readback
        step(1, 2'd0, 8'h03, 0);
        step(1, 2'd2, 8'h17, 0);
        chk("R5 R11 ctrl readback", 16'(bus_rdata), 16'h07);
        step(0, 2'd0, 8'h00, 0);
        chk("R5 forced count", 16'(bus_rdata), 16'h02);

        // R4 R9 underflow with toggle
        for (int i = 0; i < 3 && !irq_req; i++) step(0, 2'd0, 8'h00, 0);
        chk("R4 underflow seen", 16'(irq_req), 16'h1);
        chk("R9 toggle inverted", 16'(port_out), 16'h0);
        chk("R4 reloaded", 16'(bus_rdata), 16'h03);

        // R10 control write exactly at zero
        for (int i = 0; i < 8 && m_cnt != 16'd0; i++) step(0, 2'd0, 8'h00, 0);
        step(1, 2'd2, 8'h07, 0);
        chk("R10 no underflow on write", 16'(irq_req), 16'h0);
        step(0, 2'd0, 8'h00, 0);
        chk("R10 underflow deferred", 16'(irq_req), 16'h1);

        // R7 one-shot with pulse output
        step(1, 2'd2, 8'h0B, 1);
        for (int i = 0; i < 8 && !irq_req; i++) step(0, 2'd0, 8'h00, 1);
        chk("R8 pulse on pin", 16'(port_out), 16'h1);
        step(0, 2'd2, 8'h00, 1);
        chk("R7 start cleared", 16'(bus_rdata), 16'h0A);
        chk("R8 pulse one cycle", 16'(port_out), 16'h0);
        step(0, 2'd0, 8'h00, 1);
        chk("R7 count held", 16'(bus_rdata), 16'h03);

        // R3 parked by non-clock source
        step(1, 2'd2, 8'h41, 0);
        step(0, 2'd0, 8'h00, 0);
        step(0, 2'd0, 8'h00, 0);
        chk("R3 parked hold", 16'(bus_rdata), 16'h03);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit         wr  = ($urandom % 5) == 0;
            logic [1:0] a   = 2'($urandom % 3);
            logic [7:0] d   = 8'($urandom);
            bit         pin = 1'($urandom);
            if (a == 2'd0) d = d & 8'h0F;
            if (a == 2'd1) d = (($urandom % 8) == 0) ? (d & 8'h01) : 8'h00;
            if (a == 2'd2) begin
                if (($urandom % 4) != 0) d[6:5] = 2'b00;
                if (($urandom % 3) != 0) d[0] = 1'b1;
            end
            step(wr, a, d, pin);
        end

        finish_run();
    end

endmodule